// File: doc/BRIEF.md
# Inspection statistics report generator

This block sits at the end of a packet inspection pipeline and keeps running totals of the verdicts that pipeline reaches. For every packet it receives one strobed verdict made of five parts: whether the frame was well formed, whether the header check flagged an anomaly, whether a rule matched and which rule, and whether the protection stage blanked the packet. From these it maintains saturating counters for invalid, anomalous, matched and protected packets, plus one hit counter for every rule. It also turns each matched rule index into an alert code. The alert code is computed from the index, so the lookup table needs no storage.

On a request from the host side, the block freezes a copy of all counters and streams that copy out on a single asynchronous serial line. The report starts with a sync byte, carries every counter with the most significant byte first, and ends with a checksum byte. Verdicts that arrive while a report is being sent still update the live counters, so no packet goes uncounted. The bit rate comes from a run-time divisor.

Top module: `insp_stats_report`

## Requirements
- R1: After reset every counter is zero, `tx_line` is 1, `rpt_busy` is 0 and `last_alert_vld` is 0.
- R2: Counters change only in a cycle where `vd_stb` is 1. The new values are in place from the next cycle. Verdict fields presented while `vd_stb` is 0 have no effect.
- R3: On a strobe, the invalid counter increments if `vd_frame_ok` is 0, the anomaly counter if `vd_anomaly` is 1, the matched counter if `vd_hit` is 1 and the protected counter if `vd_protected` is 1. Several counters may increment on one strobe.
- R4: On a strobe with `vd_hit` at 1, only the hit counter of rule `vd_rule_id` increments. With `vd_hit` at 0, `vd_rule_id` is ignored.
- R5: The cycle after a strobe with `vd_hit` at 1, `last_alert_vld` is 1 for one cycle and `last_alert` equals (0x40 + 3 × rule index) mod 256. `last_alert` otherwise holds its value.
- R6: Each counter is CNT_W bits wide. It stops at its all-ones value instead of wrapping.
- R7: A report is the byte 0xA5, then the counters in this order: invalid, anomaly, matched, protected, rule 0 up to rule NUM_RULES-1. Each counter is sent most significant byte first. The report ends with one byte that is the XOR of all counter bytes; the sync byte is not included.
- R8: Each byte is sent as 8N1 on `tx_line`: one start bit at 0, eight data bits with the least significant bit first, one stop bit at 1. Each bit lasts `baud_div`+1 clock cycles. The line is 1 between bytes and when idle.
- R9: When `rpt_req` is 1 and `rpt_busy` is 0, `rpt_busy` is 1 from the next cycle until the stop bit of the checksum byte has ended. A request made while busy is ignored and produces no later report.
- R10: The report carries the counter values as they stood just before the request cycle. A strobe in the request cycle, or any strobe during transmission, updates the live counters but not the report being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vd_stb | input | 1 | Verdict strobe, one cycle per packet |
| vd_frame_ok | input | 1 | Frame passed validity checks |
| vd_anomaly | input | 1 | Header check flagged an anomaly |
| vd_hit | input | 1 | A rule matched |
| vd_rule_id | input | RULE_W | Index of the matched rule |
| vd_protected | input | 1 | Protection stage blanked the packet |
| rpt_req | input | 1 | Report request |
| baud_div | input | DIV_W | Bit period minus one, in clock cycles |
| tx_line | output | 1 | Serial report output |
| rpt_busy | output | 1 | Report transmission in progress |
| last_alert | output | 8 | Alert code of the most recent matched rule |
| last_alert_vld | output | 1 | Pulses when `last_alert` is updated |

## Verification
The bound checker watches the counter rules on every cycle. Counters hold still without a strobe, and the invalid counter steps by exactly one when it should. Rule counters stay quiet on a strobe with no hit, and a full counter stays full. The checker also covers the alert pulse and code, the line being high whenever no report is in flight, and the busy flag rising on an accepted request. Only the bench scenarios can show the byte content of a report, that is the order, byte significance and checksum. They also show that the snapshot is isolated from strobes in the request cycle and during transmission, that a request while busy is dropped, and that the serial timing follows a changed divisor.

// File: rtl/isr_pkg.sv
package isr_pkg;

    // Counter slots in report order
    localparam int IDX_INVALID = 0;
    localparam int IDX_ANOMALY = 1;
    localparam int IDX_MATCHED = 2;
    localparam int IDX_PROTECT = 3;
    localparam int IDX_RULE0   = 4;

    localparam logic [7:0] SYNC_BYTE = 8'hA5;

    typedef enum logic [1:0] {
        FR_IDLE   = 2'd0,
        FR_LAUNCH = 2'd1,
        FR_WAIT   = 2'd2
    } fr_state_e;

    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_DATA = 2'd1,
        PH_CSUM = 2'd2
    } fr_phase_e;

    // Alert code derived arithmetically from the rule index
    function automatic logic [7:0] alert_code(input logic [31:0] rule);
        logic [31:0] full;
        full = rule * 32'd3 + 32'h40;
        return full[7:0];
    endfunction

endpackage

// File: rtl/isr_tally.sv
module isr_tally
    import isr_pkg::*;
#(
    parameter int NUM_RULES = 8,
    parameter int CNT_W     = 32,
    localparam int RULE_W   = $clog2(NUM_RULES),
    localparam int NCNT     = IDX_RULE0 + NUM_RULES
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         stb,
    input  logic                         frame_ok,
    input  logic                         anomaly,
    input  logic                         hit,
    input  logic [RULE_W-1:0]            rule_id,
    input  logic                         prot,
    output logic [NCNT-1:0][CNT_W-1:0]   cnt_o,
    output logic [7:0]                   alert_o,
    output logic                         alert_vld_o
);

    typedef struct packed {
        logic [NCNT-1:0][CNT_W-1:0] cnt;
        logic [7:0]                 alert;
        logic                       alert_vld;
    } tally_s;

    tally_s            tally_d, tally_q;
    logic [NCNT-1:0]   bump;

    // Which slots this verdict touches
    always_comb begin
        bump              = '0;
        bump[IDX_INVALID] = !frame_ok;
        bump[IDX_ANOMALY] = anomaly;
        bump[IDX_MATCHED] = hit;
        bump[IDX_PROTECT] = prot;
        for (int r = 0; r < NUM_RULES; r++) begin
            bump[IDX_RULE0 + r] = hit && (rule_id == RULE_W'(r));
        end
    end

    always_comb begin
        tally_d           = tally_q;
        tally_d.alert_vld = 1'b0;
        if (stb) begin
            for (int k = 0; k < NCNT; k++) begin
                if (bump[k] && (tally_q.cnt[k] != {CNT_W{1'b1}})) begin
                    tally_d.cnt[k] = tally_q.cnt[k] + CNT_W'(1);
                end
            end
            if (hit) begin
                tally_d.alert     = alert_code(32'(rule_id));
                tally_d.alert_vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tally_q <= '0;
        end else begin
            tally_q <= tally_d;
        end
    end

    assign cnt_o       = tally_q.cnt;
    assign alert_o     = tally_q.alert;
    assign alert_vld_o = tally_q.alert_vld;

endmodule

// File: rtl/isr_framer.sv
module isr_framer
    import isr_pkg::*;
#(
    parameter int NCNT     = 12,
    parameter int CNT_W    = 32,
    localparam int SNAP_W  = NCNT * CNT_W,
    localparam int NDATA   = SNAP_W / 8,
    localparam int LEFT_W  = $clog2(NDATA + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic [NCNT-1:0][CNT_W-1:0]  live_cnt,
    input  logic                        tx_done,
    output logic                        tx_start,
    output logic [7:0]                  tx_byte,
    output logic                        busy
);

    typedef struct packed {
        fr_state_e          state;
        fr_phase_e          phase;
        logic [SNAP_W-1:0]  snap;
        logic [7:0]         csum;
        logic [LEFT_W-1:0]  left;
    } framer_s;

    framer_s            fr_d, fr_q;
    logic [SNAP_W-1:0]  snap_init;
    logic [7:0]         head_byte;

    // Slot 0 lands in the most significant position so it leaves first
    always_comb begin
        snap_init = '0;
        for (int k = 0; k < NCNT; k++) begin
            snap_init[SNAP_W-1-k*CNT_W -: CNT_W] = live_cnt[k];
        end
    end

    assign head_byte = fr_q.snap[SNAP_W-1 -: 8];

    always_comb begin
        fr_d     = fr_q;
        tx_start = 1'b0;
        case (fr_q.phase)
            PH_DATA: tx_byte = head_byte;
            PH_CSUM: tx_byte = fr_q.csum;
            default: tx_byte = SYNC_BYTE;
        endcase

        case (fr_q.state)
            FR_IDLE: begin
                if (req) begin
                    fr_d.snap  = snap_init;
                    fr_d.csum  = '0;
                    fr_d.left  = LEFT_W'(NDATA);
                    fr_d.phase = PH_SYNC;
                    fr_d.state = FR_LAUNCH;
                end
            end
            FR_LAUNCH: begin
                tx_start   = 1'b1;
                fr_d.state = FR_WAIT;
                if (fr_q.phase == PH_DATA) begin
                    fr_d.csum = fr_q.csum ^ head_byte;
                    fr_d.snap = fr_q.snap << 8;
                    fr_d.left = fr_q.left - LEFT_W'(1);
                end
            end
            FR_WAIT: begin
                if (tx_done) begin
                    case (fr_q.phase)
                        PH_SYNC: begin
                            fr_d.phase = PH_DATA;
                            fr_d.state = FR_LAUNCH;
                        end
                        PH_DATA: begin
                            if (fr_q.left == '0) begin
                                fr_d.phase = PH_CSUM;
                            end
                            fr_d.state = FR_LAUNCH;
                        end
                        default: fr_d.state = FR_IDLE;
                    endcase
                end
            end
            default: fr_d.state = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign busy = (fr_q.state != FR_IDLE);

endmodule

// File: rtl/isr_uart_tx.sv
module isr_uart_tx #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       data,
    input  logic [DIV_W-1:0] div,
    output logic             line,
    output logic             done
);

    typedef struct packed {
        logic             active;
        logic [8:0]       shreg;
        logic [3:0]       bitn;
        logic [DIV_W-1:0] tick;
        logic [DIV_W-1:0] div_l;
        logic             line;
        logic             done;
    } uart_s;

    uart_s ut_d, ut_q;

    always_comb begin
        ut_d      = ut_q;
        ut_d.done = 1'b0;
        if (!ut_q.active) begin
            if (start) begin
                ut_d.active = 1'b1;
                ut_d.shreg  = {1'b1, data};
                ut_d.bitn   = 4'd0;
                ut_d.tick   = div;
                ut_d.div_l  = div;
                ut_d.line   = 1'b0;
            end
        end else if (ut_q.tick != '0) begin
            ut_d.tick = ut_q.tick - DIV_W'(1);
        end else if (ut_q.bitn == 4'd9) begin
            ut_d.active = 1'b0;
            ut_d.done   = 1'b1;
            ut_d.line   = 1'b1;
        end else begin
            ut_d.line  = ut_q.shreg[0];
            ut_d.shreg = {1'b1, ut_q.shreg[8:1]};
            ut_d.bitn  = ut_q.bitn + 4'd1;
            ut_d.tick  = ut_q.div_l;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ut_q      <= '0;
            ut_q.line <= 1'b1;
        end else begin
            ut_q <= ut_d;
        end
    end

    assign line = ut_q.line;
    assign done = ut_q.done;

endmodule

// File: rtl/insp_stats_report.sv
module insp_stats_report
    import isr_pkg::*;
#(
    parameter int NUM_RULES = 8,
    parameter int CNT_W     = 32,
    parameter int DIV_W     = 16,
    localparam int RULE_W   = $clog2(NUM_RULES),
    localparam int NCNT     = IDX_RULE0 + NUM_RULES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vd_stb,
    input  logic              vd_frame_ok,
    input  logic              vd_anomaly,
    input  logic              vd_hit,
    input  logic [RULE_W-1:0] vd_rule_id,
    input  logic              vd_protected,
    input  logic              rpt_req,
    input  logic [DIV_W-1:0]  baud_div,
    output logic              tx_line,
    output logic              rpt_busy,
    output logic [7:0]        last_alert,
    output logic              last_alert_vld
);

    logic [NCNT-1:0][CNT_W-1:0] live_cnt;
    logic                       ser_start;
    logic [7:0]                 ser_byte;
    logic                       ser_done;

    isr_tally #(
        .NUM_RULES (NUM_RULES),
        .CNT_W     (CNT_W)
    ) tally_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb         (vd_stb),
        .frame_ok    (vd_frame_ok),
        .anomaly     (vd_anomaly),
        .hit         (vd_hit),
        .rule_id     (vd_rule_id),
        .prot        (vd_protected),
        .cnt_o       (live_cnt),
        .alert_o     (last_alert),
        .alert_vld_o (last_alert_vld)
    );

    isr_framer #(
        .NCNT  (NCNT),
        .CNT_W (CNT_W)
    ) framer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (rpt_req),
        .live_cnt (live_cnt),
        .tx_done  (ser_done),
        .tx_start (ser_start),
        .tx_byte  (ser_byte),
        .busy     (rpt_busy)
    );

    isr_uart_tx #(
        .DIV_W (DIV_W)
    ) uart_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ser_start),
        .data  (ser_byte),
        .div   (baud_div),
        .line  (tx_line),
        .done  (ser_done)
    );

endmodule

// File: rtl/isr_checker.sv
module isr_checker
    import isr_pkg::*;
#(
    parameter int NCNT   = 12,
    parameter int CNT_W  = 32,
    parameter int RULE_W = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        vd_stb,
    input logic                        vd_frame_ok,
    input logic                        vd_hit,
    input logic [RULE_W-1:0]           vd_rule_id,
    input logic                        rpt_req,
    input logic                        tx_line,
    input logic                        rpt_busy,
    input logic [7:0]                  last_alert,
    input logic                        last_alert_vld,
    input logic [NCNT-1:0][CNT_W-1:0]  live_cnt
);

    // R2: no strobe, no counter movement
    a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !vd_stb |=> $stable(live_cnt));

    // R3: invalid frame bumps its counter by exactly one
    a_r3_invalid_step: assert property (@(posedge clk) disable iff (!rst_n)
        (vd_stb && !vd_frame_ok && (live_cnt[IDX_INVALID] != {CNT_W{1'b1}}))
        |=> live_cnt[IDX_INVALID] == $past(live_cnt[IDX_INVALID]) + CNT_W'(1));

    // R4: rule counters untouched by a strobe without a hit
    a_r4_rules_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (vd_stb && !vd_hit) |=> $stable(live_cnt[NCNT-1:IDX_RULE0]));

    // R5: alert code and pulse follow a hit
    a_r5_alert_code: assert property (@(posedge clk) disable iff (!rst_n)
        (vd_stb && vd_hit) |=> last_alert_vld
            && (last_alert == alert_code(32'($past(vd_rule_id)))));

    a_r5_alert_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !vd_stb |=> !last_alert_vld && $stable(last_alert));

    // R6: a full counter stays full
    for (genvar k = 0; k < NCNT; k++) begin : g_sat
        a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            (live_cnt[k] == {CNT_W{1'b1}}) |=> (live_cnt[k] == {CNT_W{1'b1}}));
    end

    // R8: line rests high outside a report
    a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !rpt_busy |-> tx_line);

    // R9: an accepted request raises busy
    a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_req && !rpt_busy) |=> rpt_busy);

endmodule

bind insp_stats_report isr_checker #(
    .NCNT   (NCNT),
    .CNT_W  (CNT_W),
    .RULE_W (RULE_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .vd_stb         (vd_stb),
    .vd_frame_ok    (vd_frame_ok),
    .vd_hit         (vd_hit),
    .vd_rule_id     (vd_rule_id),
    .rpt_req        (rpt_req),
    .tx_line        (tx_line),
    .rpt_busy       (rpt_busy),
    .last_alert     (last_alert),
    .last_alert_vld (last_alert_vld),
    .live_cnt       (live_cnt)
);

// File: tb/insp_stats_report_tb.sv
module insp_stats_report_tb_top;

    localparam int NR  = 8;
    localparam int CW  = 16;
    localparam int DW  = 16;
    localparam int RW  = 3;
    localparam int NC  = 4 + NR;
    localparam int BPC = CW / 8;
    localparam int NB  = 2 + NC * BPC;
    localparam longint unsigned CMAX = (64'd1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          vd_stb, vd_frame_ok, vd_anomaly, vd_hit, vd_protected;
    logic [RW-1:0] vd_rule_id;
    logic          rpt_req;
    logic [DW-1:0] baud_div;
    logic          tx_line, rpt_busy, last_alert_vld;
    logic [7:0]    last_alert;

    always #5 clk = ~clk;

    insp_stats_report #(
        .NUM_RULES (NR),
        .CNT_W     (CW),
        .DIV_W     (DW)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .vd_stb         (vd_stb),
        .vd_frame_ok    (vd_frame_ok),
        .vd_anomaly     (vd_anomaly),
        .vd_hit         (vd_hit),
        .vd_rule_id     (vd_rule_id),
        .vd_protected   (vd_protected),
        .rpt_req        (rpt_req),
        .baud_div       (baud_div),
        .tx_line        (tx_line),
        .rpt_busy       (rpt_busy),
        .last_alert     (last_alert),
        .last_alert_vld (last_alert_vld)
    );

    int              n_chk = 0;
    int              n_fail = 0;
    bit              finished = 1'b0;
    longint unsigned model [NC];
    logic [7:0]      exp_b [NB];
    logic [7:0]      exp_alert = 8'h00;

    task automatic chk(input bit ok, input string req,
                       input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] alert_of(input int id);
        return 8'((id * 3 + 'h40) % 256);
    endfunction

    function automatic void bump(input int k, input bit en);
        if (en && model[k] != CMAX) model[k] = model[k] + 1;
    endfunction

    function automatic void model_upd(input bit ok, input bit anom, input bit hit,
                                      input int id, input bit prot);
        bump(0, !ok);
        bump(1, anom);
        bump(2, hit);
        bump(3, prot);
        if (hit) bump(4 + id, 1'b1);
    endfunction

    function automatic void build_exp();
        logic [7:0] cs;
        int         idx;
        cs       = 8'h00;
        idx      = 1;
        exp_b[0] = 8'hA5;
        for (int k = 0; k < NC; k++) begin
            for (int b = BPC - 1; b >= 0; b--) begin
                exp_b[idx] = 8'(model[k] >> (8 * b));
                cs         = cs ^ exp_b[idx];
                idx++;
            end
        end
        exp_b[NB-1] = cs;
    endfunction

    task automatic verdict(input bit ok, input bit anom, input bit hit,
                           input int id, input bit prot);
        @(negedge clk);
        vd_frame_ok  = ok;
        vd_anomaly   = anom;
        vd_hit       = hit;
        vd_rule_id   = RW'(id);
        vd_protected = prot;
        vd_stb       = 1'b1;
        @(negedge clk);
        vd_stb = 1'b0;
        model_upd(ok, anom, hit, id, prot);
        if (hit) exp_alert = alert_of(id);
        chk(last_alert_vld == hit, "R5 alert valid pulse", last_alert_vld, hit);
        chk(last_alert == exp_alert, "R5 alert code", last_alert, exp_alert);
    endtask

    task automatic rx_byte(output logic [7:0] b, output bit stop_ok, output bit to);
        int p;
        int w;
        p  = int'(baud_div) + 1;
        w  = 0;
        b  = 8'h00;
        stop_ok = 1'b0;
        @(negedge clk);
        while (tx_line !== 1'b0 && w < 5000) begin
            @(negedge clk);
            w++;
        end
        to = (w >= 5000);
        if (!to) begin
            repeat (p + p / 2) @(negedge clk);
            b[0] = tx_line;
            for (int i = 1; i < 8; i++) begin
                repeat (p) @(negedge clk);
                b[i] = tx_line;
            end
            repeat (p) @(negedge clk);
            stop_ok = (tx_line == 1'b1);
        end
    endtask

    task automatic recv_check(input string tag);
        logic [7:0] b;
        bit         stop_ok;
        bit         to;
        for (int i = 0; i < NB; i++) begin
            rx_byte(b, stop_ok, to);
            if (to) begin
                chk(1'b0, {"R8 no start bit in ", tag}, i, NB);
                break;
            end
            chk(stop_ok, "R8 stop bit", stop_ok, 1);
            chk(b == exp_b[i], $sformatf("%s byte %0d", tag, i), b, exp_b[i]);
        end
    endtask

    task automatic req_pulse();
        @(negedge clk);
        rpt_req = 1'b1;
        @(negedge clk);
        rpt_req = 1'b0;
        chk(rpt_busy == 1'b1, "R9 busy after request", rpt_busy, 1);
    endtask

    task automatic wait_idle();
        int w;
        w = 0;
        chk(rpt_busy == 1'b1, "R9 busy during last stop bit", rpt_busy, 1);
        while (rpt_busy && w < 100) begin
            @(negedge clk);
            w++;
        end
        chk(!rpt_busy && w <= int'(baud_div) + 4, "R9 busy ends after report", w, baud_div + 4);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(tx_line == 1'b1, "R1 line idle high", tx_line, 1);
        chk(rpt_busy == 1'b0, "R1 not busy", rpt_busy, 0);
        chk(last_alert_vld == 1'b0, "R1 no alert", last_alert_vld, 0);
        build_exp();
        req_pulse();
        recv_check("R1/R7 zero report");
        wait_idle();
    endtask

    task automatic t_verdicts();
        verdict(0, 0, 0, 0, 0);
        verdict(1, 1, 0, 5, 0);
        verdict(1, 0, 1, 2, 1);
        verdict(1, 0, 1, 7, 0);
        verdict(0, 1, 1, 2, 1);
        verdict(1, 0, 0, 3, 1);
        verdict(1, 0, 1, 0, 0);
        // R2: fields toggle with no strobe
        @(negedge clk);
        vd_frame_ok  = 1'b0;
        vd_anomaly   = 1'b1;
        vd_hit       = 1'b1;
        vd_rule_id   = 3'd4;
        vd_protected = 1'b1;
        repeat (6) @(negedge clk);
        chk(last_alert_vld == 1'b0, "R2 no strobe no alert", last_alert_vld, 0);
        build_exp();
        req_pulse();
        recv_check("R2/R3/R4/R7 mixed report");
        wait_idle();
    endtask

    task automatic t_overlap();
        bit fell;
        build_exp();
        // R10: strobe in the request cycle stays out of the snapshot
        @(negedge clk);
        rpt_req      = 1'b1;
        vd_frame_ok  = 1'b1;
        vd_anomaly   = 1'b0;
        vd_hit       = 1'b1;
        vd_rule_id   = 3'd6;
        vd_protected = 1'b0;
        vd_stb       = 1'b1;
        @(negedge clk);
        rpt_req = 1'b0;
        vd_stb  = 1'b0;
        model_upd(1, 0, 1, 6, 0);
        exp_alert = alert_of(6);
        chk(rpt_busy == 1'b1, "R9 busy after request", rpt_busy, 1);
        fork
            recv_check("R10 frozen snapshot");
            begin
                repeat (30) @(negedge clk);
                verdict(0, 0, 1, 1, 1);
                verdict(1, 1, 0, 0, 0);
                repeat (50) @(negedge clk);
                rpt_req = 1'b1;
                @(negedge clk);
                rpt_req = 1'b0;
                verdict(1, 0, 1, 1, 0);
            end
        join
        wait_idle();
        fell = 1'b0;
        repeat (200) begin
            @(negedge clk);
            if (tx_line == 1'b0 || rpt_busy) fell = 1'b1;
        end
        chk(!fell, "R9 request while busy ignored", fell, 0);
        build_exp();
        req_pulse();
        recv_check("R10 live counters kept");
        wait_idle();
    endtask

    task automatic t_divisor();
        @(negedge clk);
        baud_div = DW'(3);
        verdict(1, 1, 1, 3, 0);
        build_exp();
        req_pulse();
        recv_check("R8 divisor 3");
        wait_idle();
        baud_div = DW'(7);
    endtask

    task automatic t_saturate();
        @(negedge clk);
        vd_frame_ok  = 1'b0;
        vd_anomaly   = 1'b0;
        vd_hit       = 1'b0;
        vd_protected = 1'b0;
        vd_stb       = 1'b1;
        repeat (int'(CMAX) + 5) begin
            @(negedge clk);
            model_upd(0, 0, 0, 0, 0);
        end
        vd_stb = 1'b0;
        chk(model[0] == CMAX, "R6 bench model at ceiling", model[0], CMAX);
        build_exp();
        req_pulse();
        recv_check("R6 saturation report");
        wait_idle();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
    endtask

    initial begin
        for (int k = 0; k < NC; k++) model[k] = 0;
        rst_n        = 1'b0;
        vd_stb       = 1'b0;
        vd_frame_ok  = 1'b1;
        vd_anomaly   = 1'b0;
        vd_hit       = 1'b0;
        vd_rule_id   = '0;
        vd_protected = 1'b0;
        rpt_req      = 1'b0;
        baud_div     = DW'(7);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_verdicts();
        t_overlap();
        t_divisor();
        t_saturate();
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule